// File: doc/BRIEF.md
# JTAG Debug Port Access Register

This block is the target side of a debug port that sits behind a JTAG TAP controller. The TAP controller supplies the current instruction and the capture, shift and update strobes of the data-register path, all in the test clock domain. The block decodes the instruction to pick an identification register, a 35-bit port-access or bank-access request register, or an abort register. It holds the bank select register, a control/status word with sticky flags and power-up handshake bits, and a read buffer.

Each access scan returns two things: a 3-bit acknowledge taken when the scan starts, and the 32-bit read buffer. So every scan brings back the result of the read before it. Accesses to the attached access port are forwarded over a level request / one-cycle ready handshake. While such an access is outstanding the port is busy. Any access scan that began while busy gets the WAIT acknowledge and is dropped, and it can set a sticky overrun flag. An abort scan cancels an outstanding access.

Top module: `jdp_port`

## Requirements
- R1: After reset the bank select register, the control/status word and the read buffer are all zero, and no access-port request is active.
- R2: Instruction 0xE captures the 32-bit identification parameter, which has bit 0 set, and shifts it out LSB first. Any instruction other than 0x8, 0xA, 0xB or 0xE gives a 1-bit register that captures 0.
- R3: Under instructions 0xA (port access) and 0xB (bank access) a scan shifts 35 bits LSB first. Inbound bit 0 is read-not-write and bits 2:1 are register address A[3:2]. Outbound bits 2:0 are 010 when the port was idle at capture and 001 when it was busy. Bits 34:3 carry the data word.
- R4: Reads are posted: the outbound data of every access scan is the read buffer. A port read loads the buffer with the addressed register. The port addresses are A=0 (reads zero), A=1 control/status, A=2 bank select and A=3 read buffer. A read of A=3 leaves the buffer unchanged.
- R5: Bank select keeps only the access-port number in bits 31:24 and the bank in bits 7:4, and the other bits read zero. A bank access drives `ap_sel` from bits 31:24 and `ap_addr` = {bank, A[3:2], 00}. It holds `ap_req` until `ap_ready`.
- R6: When a bank read completes, its `ap_rdata` becomes the read buffer.
- R7: An access scan (0xA or 0xB) whose capture saw the port busy is dropped and forwards nothing. If control/status bit 0 (overrun detect enable) is set, it sets sticky overrun bit 1.
- R8: Sticky overrun (bit 1) and sticky error (bit 5) stay set until a control/status write carries a 1 in that bit. A 0 written there leaves the bit unchanged.
- R9: A completion with `ap_err` high sets sticky error. While sticky error is set, a bank access is discarded without a request and acknowledges 010.
- R10: An update under instruction 0x8 with data bit 0 set cancels the outstanding bank access and pulses `ap_abort` for one cycle. With data bit 0 clear it has no effect.
- R11: Control/status bits 28 and 30 are writable debug and system power-up requests. Bits 29 and 31 repeat them one cycle later.
- R12: If an abort update and an access-port completion fall in the same cycle, the abort wins: the read result and the error flag of that completion are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 4 | Current instruction from the TAP controller |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift enable |
| update_dr | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| ap_req | output | 1 | Bank access request, held until ready |
| ap_write | output | 1 | Request is a write |
| ap_sel | output | SEL_W | Selected access-port number |
| ap_addr | output | BANK_W+4 | Byte address inside the access port |
| ap_wdata | output | 32 | Write data |
| ap_abort | output | 1 | One-cycle cancel pulse |
| ap_ready | input | 1 | Access-port completion |
| ap_rdata | input | 32 | Read data, valid with ready |
| ap_err | input | 1 | Completion faulted, valid with ready |

## Verification
Two functions can meet in one cycle: an abort update and the completion of the outstanding bank read. The bench holds a bank read open with the responder stopped. It then raises `ap_ready` with a distinct data word and `ap_err` on the same clock edge as the abort update. The result is judged at the ports: two read-buffer scans must still return the value held before the cancelled read, the sticky error bit must read clear, and the abort pulse must appear with the request dropped.

// File: rtl/jdp_pkg.sv
package jdp_pkg;
  localparam int DW    = 32;
  localparam int REQ_W = DW + 3;

  localparam logic [3:0] IR_ABORT  = 4'h8;
  localparam logic [3:0] IR_DPACC  = 4'hA;
  localparam logic [3:0] IR_APACC  = 4'hB;
  localparam logic [3:0] IR_IDCODE = 4'hE;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  localparam int CS_ORUNDET = 0;
  localparam int CS_STKORUN = 1;
  localparam int CS_STKERR  = 5;
  localparam int CS_DBGREQ  = 28;

  typedef enum logic [1:0] {
    DPR_ZERO = 2'd0,
    DPR_CTRL = 2'd1,
    DPR_SEL  = 2'd2,
    DPR_RBUF = 2'd3
  } dp_reg_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [1:0]    a;
    logic          rnw;
  } dp_req_t;
endpackage

// File: rtl/jdp_scan.sv
module jdp_scan import jdp_pkg::*; #(
  parameter logic [DW-1:0] IDCODE_VAL = 32'h4A7D_0E3B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ir,
  input  logic             capture,
  input  logic             shift,
  input  logic             tdi,
  input  logic [REQ_W-1:0] cap_word,
  output logic [REQ_W-1:0] sr_o,
  output logic             tdo
);
  logic [REQ_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (capture) begin
      unique case (ir)
        IR_IDCODE:                    sr <= {3'b000, IDCODE_VAL};
        IR_DPACC, IR_APACC, IR_ABORT: sr <= cap_word;
        default:                      sr <= '0;
      endcase
    end else if (shift) begin
      unique case (ir)
        IR_IDCODE:                    sr[DW-1:0] <= {tdi, sr[DW-1:1]};
        IR_DPACC, IR_APACC, IR_ABORT: sr <= {tdi, sr[REQ_W-1:1]};
        default:                      sr[0] <= tdi;
      endcase
    end
  end

  assign sr_o = sr;
  assign tdo  = sr[0];
endmodule

// File: rtl/jdp_ctrl.sv
module jdp_ctrl import jdp_pkg::*; #(
  parameter int PWR_DOMAINS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          set_orun,
  input  logic          set_err,
  output logic [DW-1:0] ctrl_o
);
  localparam int PWR_BITS = 2 * PWR_DOMAINS;

  logic orun_en, stk_orun, stk_err;
  logic [PWR_BITS-1:0] pwr_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      orun_en  <= 1'b0;
      stk_orun <= 1'b0;
      stk_err  <= 1'b0;
    end else begin
      if (wr) orun_en <= wdata[CS_ORUNDET];
      stk_orun <= set_orun | (stk_orun & ~(wr & wdata[CS_STKORUN]));
      stk_err  <= set_err  | (stk_err  & ~(wr & wdata[CS_STKERR]));
    end
  end

  for (genvar g = 0; g < PWR_DOMAINS; g++) begin : g_pwr
    logic rq, ak;
    always_ff @(posedge clk) begin
      if (rst) begin
        rq <= 1'b0;
        ak <= 1'b0;
      end else begin
        ak <= rq;
        if (wr) rq <= wdata[CS_DBGREQ + 2*g];
      end
    end
    assign pwr_bits[2*g]   = rq;
    assign pwr_bits[2*g+1] = ak;
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[CS_ORUNDET] = orun_en;
    ctrl_o[CS_STKORUN] = stk_orun;
    ctrl_o[CS_STKERR]  = stk_err;
    ctrl_o[CS_DBGREQ +: PWR_BITS] = pwr_bits;
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[27:6], wdata[4:2], wdata[29], wdata[31]};
endmodule

// File: rtl/jdp_apif.sv
module jdp_apif import jdp_pkg::*; #(
  parameter int SEL_W = 8,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             st_write,
  input  logic [SEL_W-1:0] st_sel,
  input  logic [AW-1:0]    st_addr,
  input  logic [DW-1:0]    st_wdata,
  input  logic             abort_i,
  output logic             ap_req,
  output logic             ap_write,
  output logic [SEL_W-1:0] ap_sel,
  output logic [AW-1:0]    ap_addr,
  output logic [DW-1:0]    ap_wdata,
  output logic             ap_abort,
  input  logic             ap_ready,
  input  logic [DW-1:0]    ap_rdata,
  input  logic             ap_err,
  output logic             done_rd,
  output logic             done_err,
  output logic [DW-1:0]    done_data
);
  logic fin;
  assign fin       = ap_req & ap_ready & ~abort_i;
  assign done_rd   = fin & ~ap_write;
  assign done_err  = fin & ap_err;
  assign done_data = ap_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ap_req   <= 1'b0;
      ap_write <= 1'b0;
      ap_sel   <= '0;
      ap_addr  <= '0;
      ap_wdata <= '0;
      ap_abort <= 1'b0;
    end else begin
      ap_abort <= abort_i;
      if (abort_i || fin) begin
        ap_req <= 1'b0;
      end else if (start && !ap_req) begin
        ap_req   <= 1'b1;
        ap_write <= st_write;
        ap_sel   <= st_sel;
        ap_addr  <= st_addr;
        ap_wdata <= st_wdata;
      end
    end
  end
endmodule

// File: rtl/jdp_port.sv
module jdp_port import jdp_pkg::*; #(
  parameter logic [DW-1:0] IDCODE_VAL = 32'h4A7D_0E3B,
  parameter int SEL_W  = 8,
  parameter int BANK_W = 4,
  localparam int AP_AW = BANK_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ir,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  output logic             ap_req,
  output logic             ap_write,
  output logic [SEL_W-1:0] ap_sel,
  output logic [AP_AW-1:0] ap_addr,
  output logic [DW-1:0]    ap_wdata,
  output logic             ap_abort,
  input  logic             ap_ready,
  input  logic [DW-1:0]    ap_rdata,
  input  logic             ap_err
);
  logic [REQ_W-1:0] sr;
  dp_req_t          req;
  logic             wait_q;
  logic [DW-1:0]    ctrl_q, rdbuf_q, sel_word, dp_rdata, done_data;
  logic [SEL_W-1:0] sel_ap_q;
  logic [BANK_W-1:0] sel_bank_q;
  logic is_acc, upd_acc, accept, dp_go, ap_go, abort_go;
  logic ctrl_wr, sel_wr, set_orun, done_rd, done_err, busy;

  assign req     = dp_req_t'(sr);
  assign busy    = ap_req;
  assign is_acc  = (ir == IR_DPACC) || (ir == IR_APACC);
  assign upd_acc = update_dr && is_acc;
  assign accept  = upd_acc && !wait_q;
  assign dp_go   = accept && (ir == IR_DPACC);
  assign ap_go   = accept && (ir == IR_APACC) && !ctrl_q[CS_STKERR];
  assign abort_go = update_dr && (ir == IR_ABORT) && req.data[0];
  assign set_orun = upd_acc && wait_q && ctrl_q[CS_ORUNDET];
  assign ctrl_wr = dp_go && !req.rnw && (dp_reg_e'(req.a) == DPR_CTRL);
  assign sel_wr  = dp_go && !req.rnw && (dp_reg_e'(req.a) == DPR_SEL);

  always_comb begin
    sel_word = '0;
    sel_word[DW-1 -: SEL_W]  = sel_ap_q;
    sel_word[4 +: BANK_W]    = sel_bank_q;
  end

  always_comb begin
    unique case (dp_reg_e'(req.a))
      DPR_CTRL: dp_rdata = ctrl_q;
      DPR_SEL:  dp_rdata = sel_word;
      DPR_RBUF: dp_rdata = rdbuf_q;
      default:  dp_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q     <= 1'b0;
      sel_ap_q   <= '0;
      sel_bank_q <= '0;
      rdbuf_q    <= '0;
    end else begin
      if (capture_dr) wait_q <= is_acc && busy;
      if (sel_wr) begin
        sel_ap_q   <= req.data[DW-1 -: SEL_W];
        sel_bank_q <= req.data[4 +: BANK_W];
      end
      if (dp_go && req.rnw) rdbuf_q <= dp_rdata;
      else if (done_rd)     rdbuf_q <= done_data;
    end
  end

  jdp_scan #(.IDCODE_VAL(IDCODE_VAL)) u_scan (
    .clk(clk), .rst(rst), .ir(ir), .capture(capture_dr), .shift(shift_dr),
    .tdi(tdi), .cap_word({rdbuf_q, busy ? ACK_WAIT : ACK_OK}),
    .sr_o(sr), .tdo(tdo)
  );

  jdp_ctrl #(.PWR_DOMAINS(2)) u_ctrl (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(req.data),
    .set_orun(set_orun), .set_err(done_err), .ctrl_o(ctrl_q)
  );

  jdp_apif #(.SEL_W(SEL_W), .AW(AP_AW)) u_ap (
    .clk(clk), .rst(rst), .start(ap_go), .st_write(!req.rnw),
    .st_sel(sel_ap_q), .st_addr({sel_bank_q, req.a, 2'b00}),
    .st_wdata(req.data), .abort_i(abort_go),
    .ap_req(ap_req), .ap_write(ap_write), .ap_sel(ap_sel),
    .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_abort(ap_abort),
    .ap_ready(ap_ready), .ap_rdata(ap_rdata), .ap_err(ap_err),
    .done_rd(done_rd), .done_err(done_err), .done_data(done_data)
  );
endmodule

// File: rtl/jdp_port_chk.sv
module jdp_port_chk import jdp_pkg::*; #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    ir,
  input logic          capture_dr,
  input logic          update_dr,
  input logic          tdo,
  input logic          ap_req,
  input logic          ap_ready,
  input logic          ap_abort,
  input logic [AW-1:0] ap_addr,
  input logic [DW-1:0] ap_wdata,
  input logic [DW-1:0] ctrl_q,
  input logic          ctrl_wr
);
  logic acc;
  assign acc = (ir == IR_DPACC) || (ir == IR_APACC);

  assert_idcode_lsb_R2: assert property (@(posedge clk) disable iff (rst)
    capture_dr && (ir == IR_IDCODE) |=> tdo);

  assert_ack_wait_R3: assert property (@(posedge clk) disable iff (rst)
    capture_dr && acc && ap_req |=> tdo);

  assert_ack_ok_R3: assert property (@(posedge clk) disable iff (rst)
    capture_dr && acc && !ap_req |=> !tdo);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ap_req && !ap_ready |=> ap_req || ap_abort);

  assert_wait_drop_R7: assert property (@(posedge clk) disable iff (rst)
    update_dr && (ir == IR_APACC) && ap_req |=> $stable(ap_addr) && $stable(ap_wdata));

  assert_orun_set_R7: assert property (@(posedge clk) disable iff (rst)
    update_dr && acc && ap_req && ctrl_q[CS_ORUNDET] |=> ctrl_q[CS_STKORUN]);

  assert_sticky_err_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CS_STKERR] && !ctrl_wr |=> ctrl_q[CS_STKERR]);

  assert_abort_drop_R10: assert property (@(posedge clk) disable iff (rst)
    ap_abort |-> !ap_req);

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_q[DW-1:6], ctrl_q[4:2]};
endmodule

bind jdp_port jdp_port_chk #(.AW(AP_AW)) u_chk (.*);

// File: tb/jdp_port_bench.sv
`timescale 1ns/1ps
module jdp_port_bench;
  localparam logic [31:0] IDV = 32'h4A7D_0E3B;
  localparam logic [3:0] I_AB = 4'h8, I_DP = 4'hA, I_AP = 4'hB, I_ID = 4'hE;

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] ir = 4'h0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic tdo, ap_req, ap_write, ap_abort, ap_ready, ap_err;
  logic [7:0] ap_sel, ap_addr;
  logic [31:0] ap_wdata, ap_rdata;

  int checks = 0, errors = 0;
  bit ap_auto = 1, man_ready = 0, err_in = 0, post_abort, post_req;
  int ap_lat = 2, cnt = 0, req_count = 0;
  bit ready_a = 0;
  logic [31:0] rdata_a = '0, last_wdata;
  logic [7:0] last_sel, last_addr;
  bit last_write;

  always #2.5 clk = ~clk;

  jdp_port u_jdp_port (
    .clk(clk), .rst(rst), .ir(ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .ap_req(ap_req),
    .ap_write(ap_write), .ap_sel(ap_sel), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
    .ap_abort(ap_abort), .ap_ready(ap_ready), .ap_rdata(ap_rdata), .ap_err(ap_err)
  );

  function automatic logic [31:0] model(input logic [7:0] s, input logic [7:0] a);
    return {s, ~a, 8'hC3, a};
  endfunction

  assign ap_ready = ap_auto ? ready_a : man_ready;
  assign ap_rdata = ap_auto ? rdata_a : 32'hDEAD_BEEF;
  assign ap_err   = err_in;

  always @(negedge clk) begin
    if (rst) begin
      ready_a = 0; cnt = 0;
    end else if (ready_a) begin
      ready_a = 0;
    end else if (ap_auto && ap_req) begin
      if (cnt >= ap_lat) begin
        ready_a = 1; rdata_a = model(ap_sel, ap_addr);
        last_sel = ap_sel; last_addr = ap_addr; last_write = ap_write;
        last_wdata = ap_wdata; req_count++; cnt = 0;
      end else cnt++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic scan(input logic [3:0] irv, input logic [34:0] din, input bit collide,
                      output logic [34:0] dout);
    int n;
    n = (irv == I_ID) ? 32 : 35;
    dout = '0;
    @(negedge clk); ir = irv; capture_dr = 1;
    @(negedge clk); capture_dr = 0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo; tdi = din[i]; shift_dr = 1;
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    if (collide) man_ready = 1;
    @(negedge clk); update_dr = 0; man_ready = 0;
    post_abort = ap_abort; post_req = ap_req;
  endtask

  task automatic acc(input logic [3:0] irv, input logic [1:0] a, input bit rnw,
                     input logic [31:0] d, output logic [2:0] ack, output logic [31:0] q);
    logic [34:0] o;
    scan(irv, {d, a, rnw}, 1'b0, o);
    ack = o[2:0]; q = o[34:3];
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && ap_req; i++) @(negedge clk);
  endtask

  task automatic rd_dp(input logic [1:0] a, output logic [31:0] v);
    logic [2:0] k; logic [31:0] q;
    acc(I_DP, a, 1'b1, 32'h0, k, q);
    acc(I_DP, 2'd3, 1'b1, 32'h0, k, v);
  endtask

  task automatic wr_dp(input logic [1:0] a, input logic [31:0] v);
    logic [2:0] k; logic [31:0] q;
    acc(I_DP, a, 1'b0, v, k, q);
  endtask

  initial begin
    logic [2:0] k; logic [31:0] v, q; logic [34:0] o; int c0;
    logic [7:0] s; logic [31:0] wd;
    repeat (4) @(negedge clk); rst = 0;

    // R1 reset state
    check("R1 ap_req", {31'b0, ap_req}, 32'h0);
    acc(I_DP, 2'd1, 1'b1, 32'h0, k, q);
    check("R3 ack idle", {29'b0, k}, 32'h2);
    check("R1 rdbuf", q, 32'h0);
    acc(I_DP, 2'd3, 1'b1, 32'h0, k, v);
    check("R1 ctrl", v, 32'h0);
    rd_dp(2'd2, v); check("R1 select", v, 32'h0);

    // R2 identification and bypass
    scan(I_ID, 35'h0, 1'b0, o);
    check("R2 idcode", o[31:0], IDV);
    scan(4'h0, {35{1'b1}}, 1'b0, o);
    check("R2 bypass", {30'b0, o[1:0]}, 32'h2);

    // R4 / R5 select masking and side-effect-free read buffer
    rd_dp(2'd0, v); check("R4 addr0 zero", v, 32'h0);
    wr_dp(2'd2, 32'hFFFF_FFFF);
    rd_dp(2'd2, v); check("R5 select mask", v, 32'hFF00_00F0);
    acc(I_DP, 2'd3, 1'b1, 32'h0, k, v);
    check("R4 rdbuf stable", v, 32'hFF00_00F0);

    // R5 sweep over every bank and register address
    for (int b = 0; b < 16; b++) begin
      for (int a = 0; a < 4; a++) begin
        s = 8'(b * 16 + a * 3 + 1);
        wd = 32'(b * 32'h0101_0101 + a * 32'h1357) ^ 32'h5A5A_0000;
        wr_dp(2'd2, {s, 16'h0, 4'(b), 4'h0});
        acc(I_AP, 2'(a), 1'b0, wd, k, q);
        wait_idle();
        check("R5 sel/addr/write", {15'b0, last_sel, last_addr, last_write},
              {15'b0, s, 4'(b), 2'(a), 2'b00, 1'b1});
        check("R5 wdata", last_wdata, wd);
      end
    end

    // R6 bank reads, R4 posting
    wr_dp(2'd2, 32'h2100_0030);
    for (int a = 0; a < 4; a++) begin
      acc(I_AP, 2'(a), 1'b1, 32'h0, k, q);
      if (a > 0) check("R4 posted prev", q, model(8'h21, {4'h3, 2'(a - 1), 2'b00}));
      wait_idle();
      acc(I_DP, 2'd3, 1'b1, 32'h0, k, v);
      acc(I_DP, 2'd3, 1'b1, 32'h0, k, v);
      check("R6 read result", v, model(8'h21, {4'h3, 2'(a), 2'b00}));
    end

    // R7 / R10 / R8 WAIT, overrun, abort
    wr_dp(2'd1, 32'h1);
    c0 = req_count;
    ap_auto = 0;
    acc(I_AP, 2'd0, 1'b1, 32'h0, k, q);
    acc(I_AP, 2'd1, 1'b0, 32'h0000_0123, k, q);
    check("R7 ack wait", {29'b0, k}, 32'h1);
    check("R7 dropped", {23'b0, ap_write, ap_addr}, {23'b0, 1'b0, 8'h30});
    scan(I_AB, 35'h0, 1'b0, o);
    check("R10 abort zero no effect", {31'b0, post_req}, 32'h1);
    acc(I_DP, 2'd1, 1'b1, 32'h0, k, q);
    check("R10 still wait", {29'b0, k}, 32'h1);
    scan(I_AB, {32'h1, 3'b0}, 1'b0, o);
    check("R10 abort pulse", {30'b0, post_abort, post_req}, 32'h2);
    rd_dp(2'd1, v);
    check("R7 overrun set", {31'b0, v[1]}, 32'h1);
    wr_dp(2'd1, 32'h1);
    rd_dp(2'd1, v);
    check("R8 zero keeps", {31'b0, v[1]}, 32'h1);
    wr_dp(2'd1, 32'h3);
    rd_dp(2'd1, v);
    check("R8 w1c clears", v & 32'h3, 32'h1);
    wr_dp(2'd1, 32'h0);
    acc(I_AP, 2'd0, 1'b1, 32'h0, k, q);
    acc(I_AP, 2'd1, 1'b1, 32'h0, k, q);
    check("R7 wait no detect", {29'b0, k}, 32'h1);
    scan(I_AB, {32'h1, 3'b0}, 1'b0, o);
    rd_dp(2'd1, v);
    check("R7 overrun disabled", {31'b0, v[1]}, 32'h0);
    check("R7 nothing forwarded", 32'(req_count), 32'(c0));
    ap_auto = 1;

    // R9 sticky error and discard
    err_in = 1;
    acc(I_AP, 2'd0, 1'b0, 32'h5, k, q);
    wait_idle();
    @(negedge clk); err_in = 0;
    rd_dp(2'd1, v);
    check("R9 error set", {31'b0, v[5]}, 32'h1);
    c0 = req_count;
    acc(I_AP, 2'd0, 1'b0, 32'h7, k, q);
    check("R9 discard ack", {29'b0, k}, 32'h2);
    check("R9 no request", {31'b0, post_req}, 32'h0);
    repeat (8) @(negedge clk);
    check("R9 count same", 32'(req_count), 32'(c0));
    wr_dp(2'd1, 32'h20);
    rd_dp(2'd1, v);
    check("R8 error cleared", {31'b0, v[5]}, 32'h0);
    acc(I_AP, 2'd0, 1'b0, 32'h9, k, q);
    wait_idle();
    check("R9 forwarded again", 32'(req_count), 32'(c0 + 1));

    // R11 power handshake
    wr_dp(2'd1, 32'h5000_0000);
    rd_dp(2'd1, v);
    check("R11 acks follow", v & 32'hF000_0000, 32'hF000_0000);
    wr_dp(2'd1, 32'h0);
    rd_dp(2'd1, v);
    check("R11 acks drop", v & 32'hF000_0000, 32'h0);

    // R12 abort meets completion
    wr_dp(2'd2, 32'h7700_0030);
    rd_dp(2'd2, v);
    ap_auto = 0;
    acc(I_AP, 2'd2, 1'b1, 32'h0, k, q);
    check("R4 posted select", q, 32'h7700_0030);
    err_in = 1;
    scan(I_AB, {32'h1, 3'b0}, 1'b1, o);
    err_in = 0;
    check("R12 abort wins", {30'b0, post_abort, post_req}, 32'h2);
    acc(I_DP, 2'd3, 1'b1, 32'h0, k, v);
    acc(I_DP, 2'd3, 1'b1, 32'h0, k, v);
    check("R12 result dropped", v, 32'h7700_0030);
    rd_dp(2'd1, v);
    check("R12 error dropped", {31'b0, v[5]}, 32'h0);
    ap_auto = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule